// File: doc/BRIEF.md
# Byte-Mapped Multiply/Divide Unit

This block gives a CPU an unsigned arithmetic helper on an 8-bit register bus. The CPU loads operand bytes into write-only registers. A write to one of two trigger registers starts either a multiply or a divide. A fixed number of cycles later, the results appear in read-only byte registers.

Multiplication forms an unsigned 8x8 product with one shift-add step per cycle. Division divides a 16-bit dividend by an 8-bit divisor with one restoring step per cycle. The product and the remainder land in the same result pair. The quotient has a pair of its own. Dividing by zero gives a defined answer rather than a fault.

A busy flag is driven on a port and can also be read in a status register. A trigger write that arrives while an operation is still running drops that operation and starts again with the new operands.

Top module: `mul_div_regs`

## Requirements
- R1: After reset, every readable register (addresses 8 to 12) reads 0x00 and busy is low.
- R2: Writing address 1 (multiplier) starts an unsigned product of the operand byte held at address 0 (multiplicand) and the written byte. When the operation completes, result-low (address 10) holds bits 7:0 of the product and result-high (address 11) holds bits 15:8.
- R3: Busy goes high on the clock edge that takes a trigger write. It stays high for exactly DATA_W cycles for a multiply and 2*DATA_W cycles for a divide. It is visible on busy_o and in bit 0 of the status register at address 12; the other status bits read 0.
- R4: Writing address 4 (divisor) starts a division of the 16-bit dividend {address 3, address 2} by the written byte. When it completes, the quotient is at addresses 9:8 (high:low) and the remainder is at addresses 11:10.
- R5: A divisor of zero gives quotient 0xFFFF and a remainder equal to the dividend.
- R6: Writes to addresses 8 to 12 change no readable register.
- R7: A trigger write while busy drops the running operation and restarts with the new operands. Busy then lasts the full length of the new operation, and the dropped operation commits nothing.
- R8: Result registers hold their previous values until the completing cycle. A multiply leaves the quotient pair unchanged.
- R9: Operand registers keep their values across operations. Writing an operand while busy does not affect the running operation, but it does affect the next one.
- R10: Reads of write-only or unmapped addresses (0 to 7, 13 to 15) return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench builds the block with DATA_W = 8, so a multiply takes 8 cycles and a divide takes 16. At these lengths a restart can be placed at any point within a run and the busy window can be counted cycle by cycle. Operands of all ones reach the extremes of both operations: the full 16-bit product and a quotient of 0xFFFF. A zero divisor exercises the remainder path at its full 16-bit width.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_MCAND  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MULT   = 4'd1;
  localparam logic [ADDR_W-1:0] A_DVD_LO = 4'd2;
  localparam logic [ADDR_W-1:0] A_DVD_HI = 4'd3;
  localparam logic [ADDR_W-1:0] A_DVSR   = 4'd4;
  localparam logic [ADDR_W-1:0] A_QUO_LO = 4'd8;
  localparam logic [ADDR_W-1:0] A_QUO_HI = 4'd9;
  localparam logic [ADDR_W-1:0] A_RES_LO = 4'd10;
  localparam logic [ADDR_W-1:0] A_RES_HI = 4'd11;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd12;
endpackage

// File: rtl/mdu_operands.sv
module mdu_operands
  import mdu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     mcand_o,
  output logic [2*DW-1:0]   dvd_o
);
  localparam int LANES = 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              mcand_o <= '0;
    else if (wr_en_i && addr_i == A_MCAND)    mcand_o <= wdata_i;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_dvd
    localparam logic [ADDR_W-1:0] LANE_A = A_DVD_LO + ADDR_W'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            dvd_o[i*DW +: DW] <= '0;
      else if (wr_en_i && addr_i == LANE_A)   dvd_o[i*DW +: DW] <= wdata_i;
    end
  end
endmodule

// File: rtl/mdu_mul.sv
module mdu_mul #(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            kill_i,
  input  logic [DW-1:0]   mcand_i,
  input  logic [DW-1:0]   mult_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [2*DW-1:0] prod_o
);
  localparam int PW = 2 * DW;
  localparam int CW = $clog2(DW + 1);

  logic [PW-1:0] a_q, acc_q, acc_nxt;
  logic [DW-1:0] b_q;
  logic [CW-1:0] cnt_q;

  assign acc_nxt = acc_q + (b_q[0] ? a_q : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; acc_q <= '0; cnt_q <= '0;
    end else if (start_i) begin
      a_q   <= {{DW{1'b0}}, mcand_i};
      b_q   <= mult_i;
      acc_q <= '0;
      cnt_q <= CW'(DW);
    end else if (kill_i) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      acc_q <= acc_nxt;
      a_q   <= a_q << 1;
      b_q   <= b_q >> 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1)) && !start_i && !kill_i;
  assign prod_o = acc_nxt;
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            kill_i,
  input  logic [2*DW-1:0] dvd_i,
  input  logic [DW-1:0]   dvsr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [2*DW-1:0] quo_o,
  output logic [2*DW-1:0] rem_o
);
  localparam int QW = 2 * DW;
  localparam int CW = $clog2(QW + 1);

  logic [QW-1:0] rem_q, quo_q, rem_nxt, quo_nxt;
  logic [DW-1:0] dvs_q;
  logic [CW-1:0] cnt_q;
  logic [QW:0]   trial, diff;
  logic          ge;

  // zero divisor: every trial succeeds, giving all-ones quotient and rem = dividend
  always_comb begin
    trial   = {rem_q, quo_q[QW-1]};
    diff    = trial - {{(DW+1){1'b0}}, dvs_q};
    ge      = (trial >= {{(DW+1){1'b0}}, dvs_q});
    rem_nxt = ge ? diff[QW-1:0] : trial[QW-1:0];
    quo_nxt = {quo_q[QW-2:0], ge};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; quo_q <= '0; dvs_q <= '0; cnt_q <= '0;
    end else if (start_i) begin
      rem_q <= '0;
      quo_q <= dvd_i;
      dvs_q <= dvsr_i;
      cnt_q <= CW'(QW);
    end else if (kill_i) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      rem_q <= rem_nxt;
      quo_q <= quo_nxt;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1)) && !start_i && !kill_i;
  assign quo_o  = quo_nxt;
  assign rem_o  = rem_nxt;
endmodule

// File: rtl/mul_div_regs.sv
module mul_div_regs
  import mdu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);
  localparam int RW = 2 * DATA_W;

  logic [DATA_W-1:0] mcand;
  logic [RW-1:0]     dvd;
  logic              trig_mul, trig_div;
  logic              mul_busy, mul_done, div_busy, div_done;
  logic [RW-1:0]     prod, dquo, drem;
  logic [RW-1:0]     quo_q, res_q;

  assign trig_mul = wr_en_i && (addr_i == A_MULT);
  assign trig_div = wr_en_i && (addr_i == A_DVSR);

  mdu_operands #(.DW(DATA_W)) u_opnd (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .mcand_o(mcand), .dvd_o(dvd)
  );

  mdu_mul #(.DW(DATA_W)) u_mul (
    .clk_i, .rst_ni,
    .start_i(trig_mul), .kill_i(trig_div),
    .mcand_i(mcand), .mult_i(wdata_i),
    .busy_o(mul_busy), .done_o(mul_done), .prod_o(prod)
  );

  mdu_div #(.DW(DATA_W)) u_div (
    .clk_i, .rst_ni,
    .start_i(trig_div), .kill_i(trig_mul),
    .dvd_i(dvd), .dvsr_i(wdata_i),
    .busy_o(div_busy), .done_o(div_done), .quo_o(dquo), .rem_o(drem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      res_q <= '0;
    end else if (div_done) begin
      quo_q <= dquo;
      res_q <= drem;
    end else if (mul_done) begin
      res_q <= prod;
    end
  end

  assign busy_o = mul_busy | div_busy;

  always_comb begin
    unique case (addr_i)
      A_QUO_LO: rdata_o = quo_q[DATA_W-1:0];
      A_QUO_HI: rdata_o = quo_q[RW-1:DATA_W];
      A_RES_LO: rdata_o = res_q[DATA_W-1:0];
      A_RES_HI: rdata_o = res_q[RW-1:DATA_W];
      A_STAT:   rdata_o = {{(DATA_W-1){1'b0}}, busy_o};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdu_chk.sv
module mdu_chk
  import mdu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [3:0]      addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic            busy_o,
  input logic [DW-1:0]   mcand_q,
  input logic [2*DW-1:0] dvd_q,
  input logic [2*DW-1:0] quo_q,
  input logic [2*DW-1:0] res_q
);
  localparam int RW = 2 * DW;
  localparam int CW = $clog2(RW + 1);

  logic          trig_m, trig_d, trig, is_div;
  logic [CW-1:0] left_q;
  logic [RW-1:0] exp_quo, exp_res, wide_w;

  assign trig_m = wr_en_i && addr_i == A_MULT;
  assign trig_d = wr_en_i && addr_i == A_DVSR;
  assign trig   = trig_m || trig_d;
  assign wide_w = {{DW{1'b0}}, wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0; is_div <= 1'b0; exp_quo <= '0; exp_res <= '0;
    end else if (trig_m) begin
      left_q  <= CW'(DW);
      is_div  <= 1'b0;
      exp_res <= RW'(mcand_q) * wide_w;
    end else if (trig_d) begin
      left_q  <= CW'(RW);
      is_div  <= 1'b1;
      exp_quo <= (wdata_i == '0) ? '1 : dvd_q / wide_w;
      exp_res <= (wdata_i == '0) ? dvd_q : dvd_q % wide_w;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  AST_BUSY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (left_q != '0)); // R3

  AST_TRIGGER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> busy_o); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q != CW'(1)) |=> ($stable(quo_q) && $stable(res_q))); // R8

  AST_MUL_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q == CW'(1) && !trig && !is_div) |=> (res_q == $past(exp_res))); // R2

  AST_DIV_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q == CW'(1) && !trig && is_div) |=>
      (quo_q == $past(exp_quo) && res_q == $past(exp_res))); // R4 R5
endmodule

bind mul_div_regs mdu_chk #(.DW(DATA_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .busy_o,
  .mcand_q(mcand), .dvd_q(dvd), .quo_q(quo_q), .res_q(res_q)
);

// File: tb/tb_mul_div_regs.sv
module tb_mul_div_regs;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'd8;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  mul_div_regs #(.DATA_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [7:0]  m_mcand = '0;
  logic [15:0] m_dvd = '0, m_quo = '0, m_res = '0, p_quo = '0, p_res = '0;
  int          m_left = 0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_mcand = '0; m_dvd = '0; m_quo = '0; m_res = '0; m_left = 0;
    end else begin
      if (wr_en && (addr == 4'd1 || addr == 4'd4)) begin
        if (addr == 4'd1) begin
          p_quo = m_quo;
          p_res = 16'(m_mcand * wdata);
          m_left = 8;
        end else begin
          if (wdata == 0) begin p_quo = 16'hFFFF; p_res = m_dvd; end
          else begin p_quo = m_dvd / wdata; p_res = m_dvd % wdata; end
          m_left = 16;
        end
      end else if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin m_quo = p_quo; m_res = p_res; end
      end
      if (wr_en && addr == 4'd0) m_mcand = wdata;
      if (wr_en && addr == 4'd2) m_dvd[7:0] = wdata;
      if (wr_en && addr == 4'd3) m_dvd[15:8] = wdata;
    end
  end

  function automatic logic [7:0] model_rd(logic [3:0] a);
    case (a)
      4'd8:  return m_quo[7:0];
      4'd9:  return m_quo[15:8];
      4'd10: return m_res[7:0];
      4'd11: return m_res[15:8];
      4'd12: return {7'd0, m_left != 0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      4'd8, 4'd9:   return "R4";
      4'd10, 4'd11: return "R2";
      4'd12:        return "R3";
      default:      return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      chk("R3 busy", {15'd0, busy}, {15'd0, m_left != 0});
      chk(tag_of(addr), {8'd0, rdata}, {8'd0, model_rd(addr)});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0; addr = 4'd12;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #2;
    addr = a;
    @(negedge clk);
    chk(tag, {8'd0, rdata}, {8'd0, e});
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!busy) break;
      n++;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    idle(3);
    #2 rst_ni = 1'b1;
    // R1
    for (int a = 8; a <= 12; a++) rd(4'(a), 8'h00, "R1 reset");
    chk("R1 busy", {15'd0, busy}, 16'd0);

    // R2 / R3
    wr(4'd0, 8'h12); wr(4'd1, 8'h34);
    wait_idle(n); chk("R3 mul busy len", 16'(n), 16'd8);
    rd(4'd10, 8'hA8, "R2 lo"); rd(4'd11, 8'h03, "R2 hi");
    rd(4'd8, 8'h00, "R8 quo untouched");
    wr(4'd0, 8'hFF); wr(4'd1, 8'hFF); wait_idle(n);
    rd(4'd10, 8'h01, "R2 max lo"); rd(4'd11, 8'hFE, "R2 max hi");

    // R9
    wr(4'd1, 8'h02); wait_idle(n);
    rd(4'd10, 8'hFE, "R9 reuse lo"); rd(4'd11, 8'h01, "R9 reuse hi");
    wr(4'd1, 8'h03); wr(4'd0, 8'h10); wait_idle(n);
    rd(4'd10, 8'hFD, "R9 mid-run lo"); rd(4'd11, 8'h02, "R9 mid-run hi");
    wr(4'd1, 8'h02); wait_idle(n);
    rd(4'd10, 8'h20, "R9 next lo"); rd(4'd11, 8'h00, "R9 next hi");

    // R4
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF); wr(4'd4, 8'h01);
    wait_idle(n); chk("R3 div busy len", 16'(n), 16'd16);
    rd(4'd8, 8'hFF, "R4 quo lo"); rd(4'd9, 8'hFF, "R4 quo hi");
    rd(4'd10, 8'h00, "R4 rem lo");
    wr(4'd2, 8'h34); wr(4'd3, 8'h12); wr(4'd4, 8'h56); wait_idle(n);
    rd(4'd8, 8'h36, "R4 quo lo"); rd(4'd9, 8'h00, "R4 quo hi");
    rd(4'd10, 8'h10, "R4 rem lo"); rd(4'd11, 8'h00, "R4 rem hi");

    // R8
    wr(4'd0, 8'h03); wr(4'd1, 8'h05);
    rd(4'd10, 8'h10, "R8 hold while busy");
    rd(4'd12, 8'h01, "R3 status busy");
    wait_idle(n);
    rd(4'd10, 8'h0F, "R2 small"); rd(4'd8, 8'h36, "R8 quo kept");

    // R5
    wr(4'd2, 8'hCD); wr(4'd3, 8'hAB); wr(4'd4, 8'h00); wait_idle(n);
    rd(4'd8, 8'hFF, "R5 quo lo"); rd(4'd9, 8'hFF, "R5 quo hi");
    rd(4'd10, 8'hCD, "R5 rem lo"); rd(4'd11, 8'hAB, "R5 rem hi");

    // R6
    for (int a = 8; a <= 12; a++) wr(4'(a), 8'h55);
    rd(4'd8, 8'hFF, "R6"); rd(4'd9, 8'hFF, "R6");
    rd(4'd10, 8'hCD, "R6"); rd(4'd11, 8'hAB, "R6");
    rd(4'd12, 8'h00, "R6 status");

    // R7: div restarts a running mul
    wr(4'd2, 8'h64); wr(4'd3, 8'h00); wr(4'd0, 8'h07); wr(4'd1, 8'h09);
    idle(2);
    wr(4'd4, 8'h0A);
    wait_idle(n); chk("R7 restart busy len", 16'(n), 16'd16);
    rd(4'd8, 8'h0A, "R7 quo"); rd(4'd10, 8'h00, "R7 no product");
    // R7: mul restarts a running div
    wr(4'd4, 8'h03); idle(3); wr(4'd1, 8'h02);
    wait_idle(n); chk("R7 restart busy len", 16'(n), 16'd8);
    rd(4'd10, 8'h0E, "R7 new product"); rd(4'd8, 8'h0A, "R7 dropped div");

    // R10
    for (int a = 0; a <= 7; a++) rd(4'(a), 8'h00, "R10");
    for (int a = 13; a <= 15; a++) rd(4'(a), 8'h00, "R10");

    idle(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule